// File: doc/BRIEF.md
# Write-Through Snooping Data Cache

This block is a small direct-mapped data cache that sits between one processor and a shared memory bus used by several agents. Reads that hit return data in the cycle of the request. Reads that miss fetch one word over the bus and fill the line. Every processor write goes out to main memory as a full bus transaction. If the write hits, the cached word is updated as part of that same transaction. Writes are never deferred or merged, so back-to-back writes each wait for their own memory cycle and the processor stalls in the meantime.

To stay coherent, the cache watches all bus traffic through a separate observation port. When another agent writes a location that the cache holds, the cache either drops the line or refreshes the stored word with the written value. The `snp_mode` input selects which. Traffic that carries the cache's own agent number is ignored. A write miss does not allocate a line. The line index comes from the low word-address bits: bits [5:2] with the default of 16 lines. The remaining upper bits form the tag. The processor port is a plain request/ready handshake: the request is held until `cpu_ready` is high at a clock edge.

Top module: `wt_snoop_cache`

The controller is a five-state machine:
- IDLE: accepts requests and answers read hits.
- RD_ARB: read miss, waiting for `bus_gnt`.
- RD_WAIT: waiting for `bus_done`, then fills the line and answers.
- WR_ARB: write, waiting for `bus_gnt`.
- WR_WAIT: waiting for `bus_done`, then updates a hit line and answers.

Its transitions are:
- IDLE→RD_ARB on a read miss.
- IDLE→WR_ARB on any write.
- RD_ARB→RD_WAIT and WR_ARB→WR_WAIT on grant.
- RD_WAIT→IDLE and WR_WAIT→IDLE on done.

## Requirements
- R1: After reset every line is invalid. `cpu_ready` and `bus_valid` are low, and the first read of any address goes to the bus.
- R2: A read that hits, with no conflicting snoop, raises `cpu_ready` in the request cycle with the cached word on `cpu_rdata`. No bus transaction is started.
- R3: A read miss issues a bus read (`bus_write`=0) for the word address. On `bus_done` it returns `bus_rdata` with `cpu_ready` and fills the line, so the next read of that address hits.
- R4: Every processor write drives `bus_valid` with `bus_write`=1, the address and the data. `bus_valid`, address and direction stay stable until `bus_done`. `cpu_ready` for a write is given only in the `bus_done` cycle.
- R5: A write that hits updates the cached word. A write that misses leaves the cache unchanged (no-write-allocate).
- R6: With `snp_mode`=0, an observed write (`snp_valid`=1, `snp_write`=1) from another agent to a held word invalidates that line.
- R7: With `snp_mode`=1, an observed write from another agent to a held word replaces the cached data with `snp_data`, and the line stays valid.
- R8: Observed traffic whose `snp_src` equals the parameter `AGENT_ID` (default 0) changes nothing.
- R9: When an observed foreign write hits the line that a read in IDLE is looking up, `cpu_ready` stays low in that cycle. The read completes afterwards with the post-snoop state.
- R10: An observed foreign write to the same index but a different tag leaves the held line untouched.
- R11: Back-to-back writes each run their own complete bus transaction, and the bus request drops for at least one cycle after each `bus_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address (word aligned) |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready |
| cpu_ready | output | 1 | Request completes this cycle |
| bus_valid | output | 1 | Bus transaction request |
| bus_write | output | 1 | Bus transaction direction |
| bus_addr | output | 32 | Bus transaction address |
| bus_wdata | output | 32 | Bus write data |
| bus_gnt | input | 1 | Bus granted to this cache |
| bus_done | input | 1 | Memory cycle finished |
| bus_rdata | input | 32 | Memory read data, valid with bus_done |
| snp_valid | input | 1 | Observed bus transaction present |
| snp_write | input | 1 | Observed transaction is a write |
| snp_addr | input | 32 | Observed address |
| snp_data | input | 32 | Observed write data |
| snp_src | input | 2 | Agent number of observed transaction |
| snp_mode | input | 1 | 0 = invalidate on foreign write, 1 = update |

## Verification
A processor read lookup and a foreign-write snoop can land on the same line in the same cycle. The bench provokes this by driving a read of a cached word and an update-mode foreign write to that word at the same clock edge. It then checks that `cpu_ready` is low in that cycle. It also checks that, once the snoop is removed, the read returns the snooped value and no bus read is counted. A line fill can likewise coincide with a snoop. That case is covered by the logic that merges the pending fill into the snoop match.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ARB,
        ST_RD_WAIT,
        ST_WR_ARB,
        ST_WR_WAIT
    } wtc_state_e;
endpackage

// File: rtl/wtc_line_store.sv
module wtc_line_store #(
    parameter int LINES  = 16,
    parameter int TAG_W  = 26,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  a_idx,
    output logic              a_valid,
    output logic [TAG_W-1:0]  a_tag,
    output logic [DATA_W-1:0] a_data,
    input  logic [IDX_W-1:0]  b_idx,
    output logic              b_valid,
    output logic [TAG_W-1:0]  b_tag,
    input  logic              lw_en,
    input  logic              lw_set_tag,
    input  logic [IDX_W-1:0]  lw_idx,
    input  logic [TAG_W-1:0]  lw_tag,
    input  logic [DATA_W-1:0] lw_data,
    input  logic              sn_inv,
    input  logic              sn_upd,
    input  logic [IDX_W-1:0]  sn_idx,
    input  logic [DATA_W-1:0] sn_data
);
    logic [LINES-1:0]  vld_q;
    logic [TAG_W-1:0]  tag_q [LINES];
    logic [DATA_W-1:0] dat_q [LINES];

    assign a_valid = vld_q[a_idx];
    assign a_tag   = tag_q[a_idx];
    assign a_data  = dat_q[a_idx];
    assign b_valid = vld_q[b_idx];
    assign b_tag   = tag_q[b_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            if (lw_en && lw_set_tag) vld_q[lw_idx] <= 1'b1;
            if (sn_inv)              vld_q[sn_idx] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (lw_en) begin
            dat_q[lw_idx] <= lw_data;
            if (lw_set_tag) tag_q[lw_idx] <= lw_tag;
        end
        if (sn_upd) dat_q[sn_idx] <= sn_data;
    end
endmodule

// File: rtl/wtc_snoop_unit.sv
module wtc_snoop_unit #(
    parameter int ADDR_W   = 32,
    parameter int LINES    = 16,
    parameter int SRC_W    = 2,
    parameter int AGENT_ID = 0,
    localparam int IDX_W   = $clog2(LINES),
    localparam int TAG_W   = ADDR_W - 2 - IDX_W
) (
    input  logic              snp_valid,
    input  logic              snp_write,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [SRC_W-1:0]  snp_src,
    input  logic              snp_mode,
    input  logic              b_valid,
    input  logic [TAG_W-1:0]  b_tag,
    input  logic              lw_en,
    input  logic              lw_set_tag,
    input  logic [IDX_W-1:0]  lw_idx,
    input  logic [TAG_W-1:0]  lw_tag,
    output logic [IDX_W-1:0]  sn_idx,
    output logic              sn_hit,
    output logic              sn_inv,
    output logic              sn_upd
);
    logic [TAG_W-1:0] s_tag;
    logic             foreign_wr;
    logic             held_hit;
    logic             fill_hit;

    assign sn_idx     = snp_addr[2 +: IDX_W];
    assign s_tag      = snp_addr[ADDR_W-1 -: TAG_W];
    assign foreign_wr = snp_valid && snp_write && (snp_src != SRC_W'(AGENT_ID));
    assign held_hit   = b_valid && (b_tag == s_tag);
    // a fill landing in the same cycle counts as held so it cannot go stale
    assign fill_hit   = lw_en && lw_set_tag && (lw_idx == sn_idx) && (lw_tag == s_tag);
    assign sn_hit     = foreign_wr && (held_hit || fill_hit);
    assign sn_inv     = sn_hit && !snp_mode;
    assign sn_upd     = sn_hit && snp_mode;
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
    import wtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_req,
    input  logic       cpu_we,
    input  logic       hit,
    input  logic       conflict,
    input  logic       bus_gnt,
    input  logic       bus_done,
    output wtc_state_e state,
    output logic       accept,
    output logic       cpu_ready,
    output logic       use_bus_data,
    output logic       bus_valid,
    output logic       bus_write,
    output logic       fill_en,
    output logic       wr_upd_en
);
    wtc_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (cpu_req && cpu_we)           st_d = ST_WR_ARB;
                else if (cpu_req && !hit)        st_d = ST_RD_ARB;
            end
            ST_RD_ARB:  if (bus_gnt)  st_d = ST_RD_WAIT;
            ST_RD_WAIT: if (bus_done) st_d = ST_IDLE;
            ST_WR_ARB:  if (bus_gnt)  st_d = ST_WR_WAIT;
            ST_WR_WAIT: if (bus_done) st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        accept       = 1'b0;
        cpu_ready    = 1'b0;
        use_bus_data = 1'b0;
        bus_valid    = 1'b0;
        bus_write    = 1'b0;
        fill_en      = 1'b0;
        wr_upd_en    = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                accept    = cpu_req;
                cpu_ready = cpu_req && !cpu_we && hit && !conflict;
            end
            ST_RD_ARB: bus_valid = 1'b1;
            ST_RD_WAIT: begin
                bus_valid    = 1'b1;
                cpu_ready    = bus_done;
                use_bus_data = 1'b1;
                fill_en      = bus_done;
            end
            ST_WR_ARB: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
            end
            ST_WR_WAIT: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
                cpu_ready = bus_done;
                wr_upd_en = bus_done && hit;
            end
            default: ;
        endcase
    end

    assign state = st_q;
endmodule

// File: rtl/wt_snoop_cache.sv
module wt_snoop_cache
    import wtc_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int LINES    = 16,
    parameter int SRC_W    = 2,
    parameter int AGENT_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              bus_valid,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_gnt,
    input  logic              bus_done,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic              snp_write,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [DATA_W-1:0] snp_data,
    input  logic [SRC_W-1:0]  snp_src,
    input  logic              snp_mode
);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - 2 - IDX_W;

    wtc_state_e        state;
    logic              accept, use_bus_data, fill_en, wr_upd_en;
    logic [ADDR_W-1:0] addr_q, look_addr;
    logic [DATA_W-1:0] wdata_q;
    logic [IDX_W-1:0]  a_idx, sn_idx;
    logic [TAG_W-1:0]  a_tag, b_tag, look_tag;
    logic              a_valid, b_valid, hit, conflict;
    logic [DATA_W-1:0] a_data;
    logic              lw_en, sn_hit, sn_inv, sn_upd;
    logic [DATA_W-1:0] lw_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= cpu_addr;
            wdata_q <= cpu_wdata;
        end
    end

    assign look_addr = (state == ST_IDLE) ? cpu_addr : addr_q;
    assign a_idx     = look_addr[2 +: IDX_W];
    assign look_tag  = look_addr[ADDR_W-1 -: TAG_W];
    assign hit       = a_valid && (a_tag == look_tag);
    assign conflict  = sn_hit && (sn_idx == a_idx);
    assign lw_en     = fill_en || wr_upd_en;
    assign lw_data   = fill_en ? bus_rdata : wdata_q;

    assign cpu_rdata = use_bus_data ? bus_rdata : a_data;
    assign bus_addr  = addr_q;
    assign bus_wdata = wdata_q;

    wtc_ctrl u_ctrl (
        .clk, .rst_n, .cpu_req, .cpu_we, .hit, .conflict, .bus_gnt, .bus_done,
        .state, .accept, .cpu_ready, .use_bus_data, .bus_valid, .bus_write,
        .fill_en, .wr_upd_en
    );

    wtc_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk, .rst_n,
        .a_idx, .a_valid, .a_tag, .a_data,
        .b_idx(sn_idx), .b_valid, .b_tag,
        .lw_en, .lw_set_tag(fill_en), .lw_idx(a_idx), .lw_tag(look_tag), .lw_data,
        .sn_inv, .sn_upd, .sn_idx, .sn_data(snp_data)
    );

    wtc_snoop_unit #(.ADDR_W(ADDR_W), .LINES(LINES), .SRC_W(SRC_W), .AGENT_ID(AGENT_ID)) u_snoop (
        .snp_valid, .snp_write, .snp_addr, .snp_src, .snp_mode,
        .b_valid, .b_tag,
        .lw_en, .lw_set_tag(fill_en), .lw_idx(a_idx), .lw_tag(look_tag),
        .sn_idx, .sn_hit, .sn_inv, .sn_upd
    );
endmodule

// File: rtl/wtc_checker.sv
module wtc_checker
    import wtc_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int SRC_W    = 2,
    parameter int AGENT_ID = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_ready,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_done,
    input logic              snp_valid,
    input logic              snp_write,
    input logic [ADDR_W-1:0] snp_addr,
    input logic [SRC_W-1:0]  snp_src,
    input wtc_state_e        state
);
    a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_done |=> bus_valid && $stable(bus_addr) && $stable(bus_write));

    a_r4_write_through: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req && cpu_we && cpu_ready |-> bus_valid && bus_write && bus_done);

    a_r2_hit_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready && !bus_done |-> !bus_valid);

    a_r9_snoop_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) && cpu_req && !cpu_we && snp_valid && snp_write &&
        (snp_src != SRC_W'(AGENT_ID)) && (snp_addr[ADDR_W-1:2] == cpu_addr[ADDR_W-1:2])
        |-> !cpu_ready);

    a_r11_drop_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_done |=> !bus_valid);

    a_r1_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> cpu_req);
endmodule

bind wt_snoop_cache wtc_checker #(.ADDR_W(ADDR_W), .SRC_W(SRC_W), .AGENT_ID(AGENT_ID)) u_chk (
    .clk, .rst_n, .cpu_req, .cpu_we, .cpu_addr, .cpu_ready, .bus_valid, .bus_write,
    .bus_addr, .bus_done, .snp_valid, .snp_write, .snp_addr, .snp_src, .state
);

// File: tb/wt_snoop_cache_tb.sv
module wt_snoop_cache_tb_top;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ready;
    logic        bus_valid, bus_write;
    logic [31:0] bus_addr, bus_wdata;
    logic        bus_gnt = 1'b0, bus_done = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic        snp_valid = 1'b0, snp_write = 1'b0, snp_mode = 1'b0;
    logic [31:0] snp_addr = '0, snp_data = '0;
    logic [1:0]  snp_src = '0;

    int checks = 0, fails = 0;
    int rd_cnt = 0, wr_cnt = 0;
    logic [31:0] last_wa = '0, last_wd = '0;
    bit hung = 0;

    always #2 clk = ~clk;

    wt_snoop_cache dut_i (.*);

    function automatic logic [31:0] pat(input logic [31:0] a);
        return a ^ 32'h5A5A_0000;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model: grant one cycle after request, done LAT cycles later
    initial begin
        int ph = 0, wc = 0;
        forever begin
            @(negedge clk);
            case (ph)
                0: begin
                    bus_done = 1'b0;
                    if (rst_n && bus_valid) begin bus_gnt = 1'b1; ph = 1; wc = 0; end
                end
                1: begin
                    bus_gnt = 1'b0;
                    wc++;
                    if (wc == LAT) begin
                        bus_done  = 1'b1;
                        bus_rdata = pat(bus_addr);
                        if (bus_write) begin wr_cnt++; last_wa = bus_addr; last_wd = bus_wdata; end
                        else rd_cnt++;
                        ph = 2;
                    end
                end
                default: begin bus_done = 1'b0; ph = 0; end
            endcase
        end
    end

    task automatic cpu_op(input logic we, input logic [31:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output int cyc);
        int n = 0;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        forever begin
            #1;
            if (cpu_ready) break;
            n++;
            if (n > 100) begin hung = 1; break; end
            @(negedge clk);
        end
        rd = cpu_rdata; cyc = n;
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    task automatic snoop(input logic [31:0] a, input logic [31:0] d, input logic [1:0] src, input logic mode);
        snp_valid = 1'b1; snp_write = 1'b1; snp_addr = a; snp_data = d; snp_src = src; snp_mode = mode;
        @(negedge clk);
        snp_valid = 1'b0; snp_write = 1'b0;
    endtask

    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic        miss;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{1'b0, 32'h40, 32'h0,    32'h5A5A_0040, 1'b1},  // R1 R3 first read misses
        '{1'b0, 32'h40, 32'h0,    32'h5A5A_0040, 1'b0},  // R2 hit
        '{1'b1, 32'h40, 32'h1111, 32'h0,         1'b0},  // R4 write hit
        '{1'b0, 32'h40, 32'h0,    32'h1111,      1'b0},  // R5 updated word
        '{1'b1, 32'h80, 32'h2222, 32'h0,         1'b0},  // R5 write miss, same index
        '{1'b0, 32'h40, 32'h0,    32'h1111,      1'b0},  // R5 no allocate
        '{1'b0, 32'h84, 32'h0,    32'h5A5A_0084, 1'b1},  // R3 miss
        '{1'b0, 32'h84, 32'h0,    32'h5A5A_0084, 1'b0}   // R2 hit
    };

    initial begin
        #4000000;
        hung = 1;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int cyc, r0, w0;
        repeat (3) @(negedge clk);
        check("R1 ready after reset", {31'b0, cpu_ready}, 32'h0);
        check("R1 bus idle after reset", {31'b0, bus_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 8; i++) begin
            r0 = rd_cnt; w0 = wr_cnt;
            cpu_op(VEC[i].we, VEC[i].addr, VEC[i].wdata, rd, cyc);
            if (VEC[i].we) begin
                check("R4 one bus write", wr_cnt - w0, 1);
                check("R4 write addr", last_wa, VEC[i].addr);
                check("R4 write data", last_wd, VEC[i].wdata);
            end else begin
                check("R2 R3 data", rd, VEC[i].exp);
                check("R2 R3 bus reads", rd_cnt - r0, {31'b0, VEC[i].miss});
            end
        end

        // R6 invalidate mode
        snoop(32'h84, 32'h9999, 2'd2, 1'b0);
        r0 = rd_cnt;
        cpu_op(1'b0, 32'h84, 0, rd, cyc);
        check("R6 invalidated line misses", rd_cnt - r0, 1);
        check("R6 refetched data", rd, pat(32'h84));

        // R7 update mode
        snoop(32'h84, 32'h3333, 2'd1, 1'b1);
        r0 = rd_cnt;
        cpu_op(1'b0, 32'h84, 0, rd, cyc);
        check("R7 updated data", rd, 32'h3333);
        check("R7 still a hit", rd_cnt - r0, 0);

        // R8 own traffic ignored, both modes
        snoop(32'h84, 32'h4444, 2'd0, 1'b1);
        snoop(32'h84, 32'h4444, 2'd0, 1'b0);
        r0 = rd_cnt;
        cpu_op(1'b0, 32'h84, 0, rd, cyc);
        check("R8 own write ignored data", rd, 32'h3333);
        check("R8 own write ignored hit", rd_cnt - r0, 0);

        // R10 same index, other tag
        snoop(32'hC4, 32'h7777, 2'd3, 1'b0);
        snoop(32'hC4, 32'h7777, 2'd3, 1'b1);
        r0 = rd_cnt;
        cpu_op(1'b0, 32'h84, 0, rd, cyc);
        check("R10 other tag untouched", rd, 32'h3333);
        check("R10 still a hit", rd_cnt - r0, 0);

        // R9 snoop and read lookup in the same cycle
        r0 = rd_cnt;
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 32'h84;
        snp_valid = 1'b1; snp_write = 1'b1; snp_addr = 32'h84; snp_data = 32'h5555;
        snp_src = 2'd2; snp_mode = 1'b1;
        #1;
        check("R9 ready withheld on snoop", {31'b0, cpu_ready}, 32'h0);
        @(negedge clk);
        snp_valid = 1'b0; snp_write = 1'b0;
        #1;
        check("R9 ready after snoop", {31'b0, cpu_ready}, 32'h1);
        check("R9 post-snoop data", cpu_rdata, 32'h5555);
        @(negedge clk);
        cpu_req = 1'b0;
        check("R9 no bus read", rd_cnt - r0, 0);

        // R11 back-to-back writes
        w0 = wr_cnt;
        cpu_op(1'b1, 32'h100, 32'hAAAA, rd, cyc);
        check("R11 first write waited", {31'b0, cyc >= LAT + 1}, 32'h1);
        cpu_op(1'b1, 32'h100, 32'hBBBB, rd, cyc);
        check("R11 second write waited", {31'b0, cyc >= LAT + 1}, 32'h1);
        check("R11 two bus writes", wr_cnt - w0, 2);
        check("R11 last data", last_wd, 32'hBBBB);

        if (hung) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule